// File: doc/BRIEF.md
# Clock-Crossing Bus-to-Register Bridge

This block lets a CPU on its own clock reach a simple register port that runs on an unrelated user clock. On the CPU side it offers a memory-mapped slave with a 32-bit data bus, a word address, byte enables and a wait-request. On the user side it presents a single-cycle write strobe and a read request. The read request is answered by a read-valid strobe after any number of cycles.

Each CPU command is captured into CPU-clock holding registers, and the bridge then flips a request toggle. After two-flop synchronisation, the user side sees the change and performs one write strobe or one read request. It then flips an acknowledge toggle, which travels back through two flops. While all of this happens the CPU is held in wait-request. Only one transfer is in flight at a time. The holding registers drive the user-side address, data and byte enables directly, and they stay constant until the acknowledgement has returned.

The CPU-side machine has three states:
- C_IDLE: a read or write moves it to C_WAIT and launches the request.
- C_WAIT: it stays here until the synchronised acknowledge equals the request toggle, then moves to C_DONE.
- C_DONE: the one cycle with wait-request low. It always returns to C_IDLE.

The user-side machine has four states:
- U_IDLE: a new request moves it to U_WR for a write or to U_RD_REQ for a read.
- U_WR: one write-strobe cycle, then back to U_IDLE.
- U_RD_REQ: one request cycle. It returns to U_IDLE if read-valid is already present, otherwise it moves to U_RD_WAIT.
- U_RD_WAIT: it returns to U_IDLE when read-valid arrives.

Top module: `regbr_bridge`

## Requirements
- R1: While and after reset with no command, cpu_waitreq is 1 and cpu_rdvalid, reg_wr_en and reg_rd_req are 0.
- R2: Each CPU write yields exactly one cycle of reg_wr_en. In that cycle reg_addr equals the CPU word address and reg_wr_data equals the CPU write data.
- R3: Byte enables reach reg_wr_be unchanged, so bit k governs data bits [8k+7:8k] for k = 0 to 3.
- R4: Each CPU read yields exactly one cycle of reg_rd_req with reg_addr equal to the CPU word address. The data returned to the CPU is reg_rd_data as sampled in the user cycle where reg_rd_valid is 1.
- R5: reg_rd_valid may arrive in the same cycle as reg_rd_req or any number of cycles later. cpu_waitreq stays 1 until the read completes.
- R6: cpu_waitreq drops to 0 for exactly one CPU cycle per transfer and is 1 in the following cycle.
- R7: Only one transfer is in flight. No user-side write or read strobe occurs for a command before the previous one has completed on the CPU side, and each command produces exactly one user-side event.
- R8: cpu_rdvalid is 1 only in the completion cycle of a read, and is 0 in the completion cycle of a write.
- R9: reg_rd_valid asserted while no read is pending is ignored. It does not complete any transfer and does not change the data returned by the next read.
- R10: reg_addr, reg_wr_data and reg_wr_be stay constant while a transfer is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | CPU clock |
| cpu_rst_n | input | 1 | CPU-domain active-low reset |
| cpu_addr | input | AW | Word address of the command |
| cpu_write | input | 1 | Write command, held until wait-request drops |
| cpu_read | input | 1 | Read command, held until wait-request drops |
| cpu_wdata | input | 32 | Write data |
| cpu_be | input | 4 | Byte enables of the write |
| cpu_waitreq | output | 1 | Low for the single completion cycle |
| cpu_rdata | output | 32 | Read data, valid with cpu_rdvalid |
| cpu_rdvalid | output | 1 | Read completion strobe |
| usr_clk | input | 1 | User clock |
| usr_rst_n | input | 1 | User-domain active-low reset |
| reg_addr | output | AW | Register word address |
| reg_wr_en | output | 1 | Single-cycle write strobe |
| reg_wr_data | output | 32 | Register write data |
| reg_wr_be | output | 4 | Register byte enables |
| reg_rd_req | output | 1 | Single-cycle read request |
| reg_rd_valid | input | 1 | Read data valid strobe |
| reg_rd_data | input | 32 | Read data from the register file |

## Verification
The hardest case is a read-valid strobe that reaches the user side while the bridge has no read pending. This happens between transfers, or late after a write. The pulse could corrupt the held read data or forge an acknowledgement. The bench injects such a pulse, carrying recognisable junk data, while the bridge is idle. It then confirms that wait-request never drops, and that the next read still returns the modelled value. The read latency is also swept from zero cycles, where read-valid coincides with the request, up to twenty cycles. This exercises both exits of the request state.

// File: rtl/regbr_pkg.sv
package regbr_pkg;
    localparam int DW = 32;
    localparam int BW = DW / 8;

    typedef enum logic [1:0] {
        C_IDLE,
        C_WAIT,
        C_DONE
    } cpu_st_e;

    typedef enum logic [1:0] {
        U_IDLE,
        U_WR,
        U_RD_REQ,
        U_RD_WAIT
    } usr_st_e;
endpackage

// File: rtl/regbr_sync2.sv
module regbr_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/regbr_cpu_side.sv
module regbr_cpu_side
    import regbr_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          write,
    input  logic          read,
    input  logic [DW-1:0] wdata,
    input  logic [BW-1:0] be,
    input  logic          ack_s,
    input  logic [DW-1:0] usr_rdata,
    output logic          waitreq,
    output logic [DW-1:0] rdata,
    output logic          rdvalid,
    output logic          req_tgl,
    output logic [AW-1:0] h_addr,
    output logic [DW-1:0] h_wdata,
    output logic [BW-1:0] h_be,
    output logic          h_is_read,
    output logic          busy
);
    cpu_st_e st, nxt;
    logic [DW-1:0] rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= C_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            C_IDLE: if (write || read)   nxt = C_WAIT;
            C_WAIT: if (ack_s == req_tgl) nxt = C_DONE;
            C_DONE: nxt = C_IDLE;
            default: nxt = C_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_tgl   <= 1'b0;
            h_addr    <= '0;
            h_wdata   <= '0;
            h_be      <= '0;
            h_is_read <= 1'b0;
            rd_q      <= '0;
        end else begin
            if (st == C_IDLE && (write || read)) begin
                req_tgl   <= ~req_tgl;
                h_addr    <= addr;
                h_wdata   <= wdata;
                h_be      <= be;
                h_is_read <= !write;
            end
            if (st == C_WAIT && ack_s == req_tgl && h_is_read)
                rd_q <= usr_rdata;
        end
    end

    always_comb begin
        waitreq = (st != C_DONE);
        rdvalid = (st == C_DONE) && h_is_read;
        busy    = (st == C_WAIT);
        rdata   = rd_q;
    end
endmodule

// File: rtl/regbr_usr_side.sv
module regbr_usr_side
    import regbr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_s,
    input  logic          is_read,
    input  logic          rd_valid,
    input  logic [DW-1:0] rd_data,
    output logic          wr_en,
    output logic          rd_req,
    output logic          ack_tgl,
    output logic [DW-1:0] rd_hold
);
    usr_st_e st, nxt;
    logic req_seen;
    logic new_req;
    logic rd_open;

    assign new_req = (req_s != req_seen);
    assign rd_open = (st == U_RD_REQ) || (st == U_RD_WAIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= U_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            U_IDLE:    if (new_req) nxt = is_read ? U_RD_REQ : U_WR;
            U_WR:      nxt = U_IDLE;
            U_RD_REQ:  nxt = rd_valid ? U_IDLE : U_RD_WAIT;
            U_RD_WAIT: if (rd_valid) nxt = U_IDLE;
            default:   nxt = U_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_seen <= 1'b0;
            ack_tgl  <= 1'b0;
            rd_hold  <= '0;
        end else begin
            if (st == U_IDLE && new_req) req_seen <= req_s;
            if (st == U_WR) ack_tgl <= ~ack_tgl;
            if (rd_open && rd_valid) begin
                rd_hold <= rd_data;
                ack_tgl <= ~ack_tgl;
            end
        end
    end

    always_comb begin
        wr_en  = (st == U_WR);
        rd_req = (st == U_RD_REQ);
    end
endmodule

// File: rtl/regbr_bridge.sv
module regbr_bridge
    import regbr_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          cpu_clk,
    input  logic          cpu_rst_n,
    input  logic [AW-1:0] cpu_addr,
    input  logic          cpu_write,
    input  logic          cpu_read,
    input  logic [31:0]   cpu_wdata,
    input  logic [3:0]    cpu_be,
    output logic          cpu_waitreq,
    output logic [31:0]   cpu_rdata,
    output logic          cpu_rdvalid,
    input  logic          usr_clk,
    input  logic          usr_rst_n,
    output logic [AW-1:0] reg_addr,
    output logic          reg_wr_en,
    output logic [31:0]   reg_wr_data,
    output logic [3:0]    reg_wr_be,
    output logic          reg_rd_req,
    input  logic          reg_rd_valid,
    input  logic [31:0]   reg_rd_data
);
    logic          req_tgl, req_s, ack_tgl, ack_s;
    logic          h_is_read, c_busy;
    logic [DW-1:0] rd_hold;

    regbr_cpu_side #(.AW(AW)) u_cpu (
        .clk(cpu_clk), .rst_n(cpu_rst_n),
        .addr(cpu_addr), .write(cpu_write), .read(cpu_read),
        .wdata(cpu_wdata), .be(cpu_be),
        .ack_s(ack_s), .usr_rdata(rd_hold),
        .waitreq(cpu_waitreq), .rdata(cpu_rdata), .rdvalid(cpu_rdvalid),
        .req_tgl(req_tgl), .h_addr(reg_addr), .h_wdata(reg_wr_data),
        .h_be(reg_wr_be), .h_is_read(h_is_read), .busy(c_busy)
    );

    regbr_sync2 u_req_sync (.clk(usr_clk), .rst_n(usr_rst_n), .d(req_tgl), .q(req_s));
    regbr_sync2 u_ack_sync (.clk(cpu_clk), .rst_n(cpu_rst_n), .d(ack_tgl), .q(ack_s));

    regbr_usr_side u_usr (
        .clk(usr_clk), .rst_n(usr_rst_n),
        .req_s(req_s), .is_read(h_is_read),
        .rd_valid(reg_rd_valid), .rd_data(reg_rd_data),
        .wr_en(reg_wr_en), .rd_req(reg_rd_req),
        .ack_tgl(ack_tgl), .rd_hold(rd_hold)
    );
endmodule

// File: rtl/regbr_checker.sv
module regbr_checker #(
    parameter int AW = 16
) (
    input logic          cpu_clk,
    input logic          cpu_rst_n,
    input logic          usr_clk,
    input logic          usr_rst_n,
    input logic          cpu_waitreq,
    input logic          cpu_rdvalid,
    input logic          c_busy,
    input logic [AW-1:0] reg_addr,
    input logic [31:0]   reg_wr_data,
    input logic [3:0]    reg_wr_be,
    input logic          reg_wr_en,
    input logic          reg_rd_req
);
    a_r2_wr_single: assert property (@(posedge usr_clk) disable iff (!usr_rst_n)
        reg_wr_en |=> !reg_wr_en);

    a_r4_rd_single: assert property (@(posedge usr_clk) disable iff (!usr_rst_n)
        reg_rd_req |=> !reg_rd_req);

    a_r7_no_overlap: assert property (@(posedge usr_clk) disable iff (!usr_rst_n)
        !(reg_rd_req && reg_wr_en));

    a_r6_one_done_cycle: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
        !cpu_waitreq |=> cpu_waitreq);

    a_r8_rdvalid_in_done: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
        cpu_rdvalid |-> !cpu_waitreq);

    a_r10_hold_stable: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
        (c_busy && $past(c_busy)) |-> ($stable(reg_addr) && $stable(reg_wr_data) && $stable(reg_wr_be)));
endmodule

bind regbr_bridge regbr_checker #(.AW(AW)) u_chk (
    .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n),
    .usr_clk(usr_clk), .usr_rst_n(usr_rst_n),
    .cpu_waitreq(cpu_waitreq), .cpu_rdvalid(cpu_rdvalid), .c_busy(c_busy),
    .reg_addr(reg_addr), .reg_wr_data(reg_wr_data), .reg_wr_be(reg_wr_be),
    .reg_wr_en(reg_wr_en), .reg_rd_req(reg_rd_req)
);

// File: tb/sim_regbr_bridge.sv
`timescale 1ns/1ps
module sim_regbr_bridge;
    localparam int AW = 16;

    logic          cpu_clk = 0, usr_clk = 0;
    logic          cpu_rst_n = 0, usr_rst_n = 0;
    logic [AW-1:0] cpu_addr = '0;
    logic          cpu_write = 0, cpu_read = 0;
    logic [31:0]   cpu_wdata = '0;
    logic [3:0]    cpu_be = '0;
    logic          cpu_waitreq, cpu_rdvalid;
    logic [31:0]   cpu_rdata;
    logic [AW-1:0] reg_addr;
    logic          reg_wr_en, reg_rd_req;
    logic [31:0]   reg_wr_data;
    logic [3:0]    reg_wr_be;
    logic          reg_rd_valid;
    logic [31:0]   reg_rd_data;

    logic          rv_resp = 0, rv_stray = 0;
    logic [31:0]   resp_data = '0;
    assign reg_rd_valid = rv_resp | rv_stray;
    assign reg_rd_data  = rv_stray ? 32'hDEADBEEF : resp_data;

    always #2.5 cpu_clk = ~cpu_clk;
    always #3.5 usr_clk = ~usr_clk;

    regbr_bridge #(.AW(AW)) u0 (.*);

    int checks = 0, failures = 0;
    int wr_cnt = 0, rd_cnt = 0, rd_lat = 0;
    logic [AW-1:0] last_wa, last_ra;
    logic [31:0]   last_wd;
    logic [3:0]    last_wbe;

    function automatic logic [31:0] model(input logic [AW-1:0] a);
        return {a, ~a} ^ 32'h3C96A55A;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // user-side responder: records strobes, answers reads after rd_lat cycles
    initial begin
        bit pend = 0;
        int cnt = 0;
        forever begin
            @(negedge usr_clk);
            rv_resp = 0;
            if (reg_wr_en) begin
                wr_cnt++; last_wa = reg_addr; last_wd = reg_wr_data; last_wbe = reg_wr_be;
            end
            if (reg_rd_req) begin
                rd_cnt++; last_ra = reg_addr; pend = 1; cnt = rd_lat;
            end
            if (pend) begin
                if (cnt == 0) begin
                    rv_resp = 1; resp_data = model(last_ra); pend = 0;
                end else cnt--;
            end
        end
    end

    task automatic cpu_xfer(input bit is_rd, input logic [AW-1:0] a, input logic [31:0] d,
                            input logic [3:0] be, output logic [31:0] rdat, output bit rv);
        int n = 0;
        @(negedge cpu_clk);
        cpu_addr = a; cpu_wdata = d; cpu_be = be;
        cpu_write = !is_rd; cpu_read = is_rd;
        @(negedge cpu_clk);
        while (cpu_waitreq && n < 2000) begin
            @(negedge cpu_clk); n++;
        end
        chk(n < 2000, "R5 completion", n, 0);
        rdat = cpu_rdata; rv = cpu_rdvalid;
        @(posedge cpu_clk);
        @(negedge cpu_clk);
        cpu_write = 0; cpu_read = 0;
        chk(cpu_waitreq == 1, "R6 waitreq back high", cpu_waitreq, 1);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge cpu_clk);
        chk(cpu_waitreq == 1 && cpu_rdvalid == 0, "R1 cpu side in reset", {cpu_waitreq, cpu_rdvalid}, 2);
        cpu_rst_n = 1; usr_rst_n = 1;
        repeat (5) @(negedge usr_clk);
        chk(reg_wr_en == 0 && reg_rd_req == 0, "R1 user side idle", {reg_wr_en, reg_rd_req}, 0);
        chk(cpu_waitreq == 1 && cpu_rdvalid == 0, "R1 cpu side idle", {cpu_waitreq, cpu_rdvalid}, 2);
    endtask

    task automatic t_write(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
        logic [31:0] rd; bit rv;
        int w0 = wr_cnt, r0 = rd_cnt;
        cpu_xfer(0, a, d, be, rd, rv);
        chk(wr_cnt == w0 + 1, "R2 one write strobe", wr_cnt - w0, 1);
        chk(rd_cnt == r0, "R7 no read strobe on write", rd_cnt - r0, 0);
        chk(last_wa == a, "R2 address", last_wa, a);
        chk(last_wd == d, "R2 data", last_wd, d);
        chk(last_wbe == be, "R3 byte enables", last_wbe, be);
        chk(rv == 0, "R8 no rdvalid on write", rv, 0);
    endtask

    task automatic t_read(input logic [AW-1:0] a, input int lat);
        logic [31:0] rd; bit rv;
        int w0 = wr_cnt, r0 = rd_cnt;
        rd_lat = lat;
        cpu_xfer(1, a, 32'h0, 4'h0, rd, rv);
        chk(rd_cnt == r0 + 1, "R4 one read request", rd_cnt - r0, 1);
        chk(wr_cnt == w0, "R7 no write strobe on read", wr_cnt - w0, 0);
        chk(last_ra == a, "R4 read address", last_ra, a);
        chk(rv == 1, "R8 rdvalid on read", rv, 1);
        chk(rd == model(a), $sformatf("R5 read data latency %0d", lat), rd, model(a));
    endtask

    task automatic t_stray;
        int r0 = rd_cnt;
        bit dropped = 0;
        @(negedge usr_clk); rv_stray = 1;
        @(negedge usr_clk); @(negedge usr_clk); rv_stray = 0;
        repeat (20) begin
            @(negedge cpu_clk);
            if (!cpu_waitreq || cpu_rdvalid) dropped = 1;
        end
        chk(!dropped, "R9 stray valid completes nothing", dropped, 0);
        chk(rd_cnt == r0, "R9 no read request", rd_cnt - r0, 0);
        t_read(16'h0077, 2);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_write(16'h0000, 32'h12345678, 4'hF);
                t_write(16'h0801, 32'hA5A5_0F0F, 4'h1);
                t_write(16'hFFFF, 32'hFFFF_0000, 4'hA);
                t_write(16'h1234, 32'h0000_0001, 4'h0);
                t_read(16'h0010, 0);
                t_read(16'h0011, 1);
                t_read(16'h2000, 5);
                t_read(16'hFFFE, 20);
                t_write(16'h0040, 32'hCAFEF00D, 4'h6);
                t_read(16'h0040, 3);
                t_stray();
            end
            begin
                #1000000;
                chk(0, "watchdog", 0, 1);
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule